// File: doc/BRIEF.md
# System Power State Controller

This block owns the power state of the whole chip. It can be in one of four states: full operation, light sleep, deep sleep with DRAM retained, or off. Software asks for a target state with a one-cycle request. The block checks the request against the current states of the processor clusters. It rejects an illegal request and accepts a legal one. For a legal request it switches the domain enables in a fixed order and then holds the new state.

The block has a system counter and a wake-up timer in the always-on domain. In light sleep the counter keeps running. The block leaves light sleep when the counter reaches a programmed compare value, or when any always-on wake line goes high. The interrupt controller domain and the system domain are then restored in a fixed order, and the clusters are released. In deep sleep and off, the counter domain is also powered down, so the block cannot wake itself. Only the power-on reset brings the system back. Deep sleep and off differ in one output only: the DRAM retention request.

The reset input is asynchronous and active-low. Inside the block it is released synchronously, through two flops. After reset the block is in full operation with every domain powered.

Top module: `soc_pstate_ctrl`

## Requirements
- R1: After reset, `sys_state` is 00 (RUN). `sys_pwr_en`, `gic_pwr_en` and `aon_pwr_en` are 1. `dram_ret_req`, `clus_wake_rel`, `busy` and `req_err` are 0. While settled in RUN, all three enables stay 1 and `dram_ret_req` stays 0.
- R2: The `req_state` encoding is 00 RUN, 01 SLEEP, 10 DEEPSLEEP, 11 OFF. A request is acted on only when `req_valid` is 1, the state is RUN and `busy` is 0. A request made at any other time changes no output. A legal RUN request while in RUN changes nothing.
- R3: Each cluster has a 2-bit code in `clus_state[2i+1:2i]`: 00 running, 01 sleeping with cache kept, 10 sleeping, 11 off. A SLEEP request is legal only if at least one cluster code is 01 or 10 and no cluster code is 00.
- R4: An OFF request is legal only if every cluster code is 11. A DEEPSLEEP request is legal only if no cluster code is 00.
- R5: An illegal request sets `req_err` at the next clock edge. `req_err` then stays 1 until reset. The state stays RUN and `busy` stays 0.
- R6: When a low-power request is accepted, `gic_pwr_en` falls at the next edge and `sys_pwr_en` falls STEP_CYC cycles later. The block reaches SLEEP 2*STEP_CYC cycles after acceptance. In settled SLEEP, `aon_pwr_en` is 1 and the other enables are 0.
- R7: In settled SLEEP the block starts waking at the first edge where either of two conditions holds. The first is `timer_en` = 1 with `sys_count` >= `wake_at`. The second is any `aon_wake` bit at 1. A compare value at or below the count on SLEEP entry makes the block spend exactly one cycle in SLEEP.
- R8: On wake, `sys_pwr_en` rises first. `gic_pwr_en` rises STEP_CYC cycles later. `clus_wake_rel` is then 1 for STEP_CYC cycles. After that the state is RUN with `busy` at 0.
- R9: A DEEPSLEEP request powers down `aon_pwr_en` STEP_CYC cycles after `sys_pwr_en` falls. In settled DEEPSLEEP, `dram_ret_req` is 1 and all three enables are 0. Settled OFF is the same except that `dram_ret_req` is 0. In either state, wake lines, the timer and requests have no effect. Only reset leaves them.
- R10: `sys_count` is 0 after reset. It increases by 1 on every clock edge while `aon_pwr_en` is 1, and it holds while `aon_pwr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active-low |
| clus_state | input | 2*N_CLUS | Per-cluster power state codes |
| req_valid | input | 1 | One-cycle request strobe |
| req_state | input | 2 | Requested system state |
| timer_en | input | 1 | Enables the wake-up timer compare |
| wake_at | input | CNT_W | Wake-up timer compare value |
| aon_wake | input | N_WAKE | Level wake lines from the always-on domain |
| sys_count | output | CNT_W | System counter value |
| sys_pwr_en | output | 1 | System domain power enable |
| gic_pwr_en | output | 1 | Interrupt controller domain power enable |
| aon_pwr_en | output | 1 | Counter and timer domain power enable |
| dram_ret_req | output | 1 | DRAM retention request |
| clus_wake_rel | output | 1 | Cluster wake release |
| busy | output | 1 | A transition sequence is in progress |
| sys_state | output | 2 | Current system state, same encoding as req_state |
| req_err | output | 1 | Sticky illegal-request flag |

## Verification
Cluster state vectors are drawn at random, including runs where every cluster is off, and are paired with random target states. This separates three checks: the SLEEP rule that needs at least one sleeping cluster, the DEEPSLEEP rule that forbids any running cluster, and the OFF rule that needs every cluster off. Light sleep is left in two ways. The first uses timer compare values both past and ahead of the count at entry, which separates an immediate wake from a counted one. The second uses single wake lines, with the timer off. Requests made during a sequence, and requests and wake lines applied in deep sleep and off, show that those states ignore stimulus. They also show that the two deep states differ only in DRAM retention.

// File: rtl/soc_pstate_pkg.sv
package soc_pstate_pkg;

  typedef enum logic [1:0] {
    SYS_RUN   = 2'b00,
    SYS_SLEEP = 2'b01,
    SYS_DEEP  = 2'b10,
    SYS_OFF   = 2'b11
  } sys_state_e;

  localparam logic [1:0] CL_RUN       = 2'b00;
  localparam logic [1:0] CL_SLEEP_RET = 2'b01;
  localparam logic [1:0] CL_SLEEP     = 2'b10;
  localparam logic [1:0] CL_OFF       = 2'b11;

  typedef enum logic [3:0] {
    PH_RUN    = 4'd0,
    PH_DN_GIC = 4'd1,
    PH_DN_SYS = 4'd2,
    PH_DN_AON = 4'd3,
    PH_SLEEP  = 4'd4,
    PH_DEEP   = 4'd5,
    PH_OFF    = 4'd6,
    PH_UP_SYS = 4'd7,
    PH_UP_GIC = 4'd8,
    PH_UP_REL = 4'd9
  } phase_e;

  typedef struct packed {
    logic any_run;
    logic any_sleep;
    logic all_off;
  } clus_sum_t;

  typedef struct packed {
    logic       sys_en;
    logic       gic_en;
    logic       aon_en;
    logic       dram_ret;
    logic       clus_rel;
    logic       busy;
    sys_state_e state;
  } dom_out_t;

  function automatic logic target_legal(input sys_state_e tgt, input clus_sum_t s);
    logic ok;
    unique case (tgt)
      SYS_RUN:   ok = 1'b1;
      SYS_SLEEP: ok = s.any_sleep && !s.any_run;
      SYS_DEEP:  ok = !s.any_run;
      SYS_OFF:   ok = s.all_off;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pstate_cluster_sum.sv
module pstate_cluster_sum
  import soc_pstate_pkg::*;
#(
  parameter int N_CLUS = 4
) (
  input  logic [2*N_CLUS-1:0] clus_state,
  output clus_sum_t           sum
);

  logic [N_CLUS-1:0] is_run;
  logic [N_CLUS-1:0] is_sleep;
  logic [N_CLUS-1:0] is_off;

  for (genvar g = 0; g < N_CLUS; g++) begin : g_clus
    logic [1:0] code;
    assign code        = clus_state[2*g +: 2];
    assign is_run[g]   = (code == CL_RUN);
    assign is_sleep[g] = (code == CL_SLEEP_RET) || (code == CL_SLEEP);
    assign is_off[g]   = (code == CL_OFF);
  end

  always_comb begin
    sum.any_run   = |is_run;
    sum.any_sleep = |is_sleep;
    sum.all_off   = &is_off;
  end

endmodule

// File: rtl/pstate_wake_timer.sv
module pstate_wake_timer #(
  parameter int CNT_W  = 64,
  parameter int N_WAKE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              timer_en,
  input  logic [CNT_W-1:0]  wake_at,
  input  logic [N_WAKE-1:0] aon_wake,
  output logic [CNT_W-1:0]  count,
  output logic              wake_hit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             timer_due;
  logic             event_due;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    timer_due = timer_en && (cnt_q >= wake_at);
    event_due = |aon_wake;
    wake_hit  = timer_due || event_due;
  end

  assign count = cnt_q;

endmodule

// File: rtl/pstate_seq.sv
module pstate_seq
  import soc_pstate_pkg::*;
#(
  parameter int STEP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_state,
  input  clus_sum_t  clus_sum,
  input  logic       wake_hit,
  output phase_e     phase_nx,
  output sys_state_e tgt_nx,
  output logic       err
);

  localparam int STEP_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYC - 1);

  phase_e            phase_q, phase_d;
  sys_state_e        tgt_q, tgt_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              err_q, err_d;
  logic              step_done;
  logic              in_seq;
  sys_state_e        req_tgt;

  assign req_tgt   = sys_state_e'(req_state);
  assign step_done = (step_q == STEP_LAST);

  always_comb begin
    unique case (phase_q)
      PH_DN_GIC, PH_DN_SYS, PH_DN_AON,
      PH_UP_SYS, PH_UP_GIC, PH_UP_REL: in_seq = 1'b1;
      default:                         in_seq = 1'b0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    tgt_d   = tgt_q;
    err_d   = err_q;
    step_d  = '0;
    if (in_seq && !step_done) begin
      step_d = step_q + STEP_W'(1);
    end
    unique case (phase_q)
      PH_RUN: begin
        if (req_valid) begin
          if (!target_legal(req_tgt, clus_sum)) begin
            err_d = 1'b1;
          end else if (req_tgt != SYS_RUN) begin
            tgt_d   = req_tgt;
            phase_d = PH_DN_GIC;
          end
        end
      end
      PH_DN_GIC: if (step_done) phase_d = PH_DN_SYS;
      PH_DN_SYS: if (step_done) phase_d = (tgt_q == SYS_SLEEP) ? PH_SLEEP : PH_DN_AON;
      PH_DN_AON: if (step_done) phase_d = (tgt_q == SYS_DEEP) ? PH_DEEP : PH_OFF;
      PH_SLEEP:  if (wake_hit)  phase_d = PH_UP_SYS;
      PH_UP_SYS: if (step_done) phase_d = PH_UP_GIC;
      PH_UP_GIC: if (step_done) phase_d = PH_UP_REL;
      PH_UP_REL: begin
        if (step_done) begin
          phase_d = PH_RUN;
          tgt_d   = SYS_RUN;
        end
      end
      PH_DEEP, PH_OFF: phase_d = phase_q;
      default: phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      tgt_q   <= SYS_RUN;
      step_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tgt_q   <= tgt_d;
      step_q  <= step_d;
      err_q   <= err_d;
    end
  end

  assign phase_nx = phase_d;
  assign tgt_nx   = tgt_d;
  assign err      = err_q;

endmodule

// File: rtl/pstate_dom_out.sv
module pstate_dom_out
  import soc_pstate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     phase_nx,
  input  sys_state_e tgt_nx,
  output dom_out_t   dom
);

  dom_out_t dom_d;
  dom_out_t dom_q;
  logic     deep_tgt;

  assign deep_tgt = (tgt_nx == SYS_DEEP);

  always_comb begin
    dom_d = '0;
    unique case (phase_nx)
      PH_RUN: begin
        dom_d.sys_en = 1'b1; dom_d.gic_en = 1'b1; dom_d.aon_en = 1'b1;
        dom_d.state  = SYS_RUN;
      end
      PH_DN_GIC: begin
        dom_d.sys_en = 1'b1; dom_d.aon_en = 1'b1; dom_d.dram_ret = deep_tgt;
        dom_d.busy   = 1'b1; dom_d.state  = SYS_RUN;
      end
      PH_DN_SYS: begin
        dom_d.aon_en = 1'b1; dom_d.dram_ret = deep_tgt;
        dom_d.busy   = 1'b1; dom_d.state    = SYS_RUN;
      end
      PH_DN_AON: begin
        dom_d.dram_ret = deep_tgt; dom_d.busy = 1'b1; dom_d.state = SYS_RUN;
      end
      PH_SLEEP: begin
        dom_d.aon_en = 1'b1; dom_d.state = SYS_SLEEP;
      end
      PH_DEEP: begin
        dom_d.dram_ret = 1'b1; dom_d.state = SYS_DEEP;
      end
      PH_OFF: begin
        dom_d.state = SYS_OFF;
      end
      PH_UP_SYS: begin
        dom_d.sys_en = 1'b1; dom_d.aon_en = 1'b1;
        dom_d.busy   = 1'b1; dom_d.state  = SYS_SLEEP;
      end
      PH_UP_GIC: begin
        dom_d.sys_en = 1'b1; dom_d.gic_en = 1'b1; dom_d.aon_en = 1'b1;
        dom_d.busy   = 1'b1; dom_d.state  = SYS_SLEEP;
      end
      PH_UP_REL: begin
        dom_d.sys_en   = 1'b1; dom_d.gic_en = 1'b1; dom_d.aon_en = 1'b1;
        dom_d.clus_rel = 1'b1; dom_d.busy   = 1'b1; dom_d.state  = SYS_SLEEP;
      end
      default: begin
        dom_d.sys_en = 1'b1; dom_d.gic_en = 1'b1; dom_d.aon_en = 1'b1;
        dom_d.state  = SYS_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_q.sys_en   <= 1'b1;
      dom_q.gic_en   <= 1'b1;
      dom_q.aon_en   <= 1'b1;
      dom_q.dram_ret <= 1'b0;
      dom_q.clus_rel <= 1'b0;
      dom_q.busy     <= 1'b0;
      dom_q.state    <= SYS_RUN;
    end else begin
      dom_q <= dom_d;
    end
  end

  assign dom = dom_q;

endmodule

// File: rtl/soc_pstate_ctrl.sv
module soc_pstate_ctrl
  import soc_pstate_pkg::*;
#(
  parameter int N_CLUS   = 4,
  parameter int N_WAKE   = 4,
  parameter int CNT_W    = 64,
  parameter int STEP_CYC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*N_CLUS-1:0] clus_state,
  input  logic                req_valid,
  input  logic [1:0]          req_state,
  input  logic                timer_en,
  input  logic [CNT_W-1:0]    wake_at,
  input  logic [N_WAKE-1:0]   aon_wake,
  output logic [CNT_W-1:0]    sys_count,
  output logic                sys_pwr_en,
  output logic                gic_pwr_en,
  output logic                aon_pwr_en,
  output logic                dram_ret_req,
  output logic                clus_wake_rel,
  output logic                busy,
  output logic [1:0]          sys_state,
  output logic                req_err
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  clus_sum_t  clus_sum;
  logic       wake_hit;
  phase_e     phase_nx;
  sys_state_e tgt_nx;
  dom_out_t   dom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  pstate_cluster_sum #(.N_CLUS(N_CLUS)) u_sum (
    .clus_state (clus_state),
    .sum        (clus_sum)
  );

  pstate_wake_timer #(.CNT_W(CNT_W), .N_WAKE(N_WAKE)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cnt_en   (dom.aon_en),
    .timer_en (timer_en),
    .wake_at  (wake_at),
    .aon_wake (aon_wake),
    .count    (sys_count),
    .wake_hit (wake_hit)
  );

  pstate_seq #(.STEP_CYC(STEP_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_state (req_state),
    .clus_sum  (clus_sum),
    .wake_hit  (wake_hit),
    .phase_nx  (phase_nx),
    .tgt_nx    (tgt_nx),
    .err       (req_err)
  );

  pstate_dom_out u_dom (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .phase_nx (phase_nx),
    .tgt_nx   (tgt_nx),
    .dom      (dom)
  );

  assign sys_pwr_en    = dom.sys_en;
  assign gic_pwr_en    = dom.gic_en;
  assign aon_pwr_en    = dom.aon_en;
  assign dram_ret_req  = dom.dram_ret;
  assign clus_wake_rel = dom.clus_rel;
  assign busy          = dom.busy;
  assign sys_state     = dom.state;

endmodule

// File: rtl/soc_pstate_ctrl_chk.sv
module soc_pstate_ctrl_chk
  import soc_pstate_pkg::*;
#(
  parameter int N_CLUS = 4,
  parameter int CNT_W  = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*N_CLUS-1:0] clus_state,
  input logic                req_valid,
  input logic [1:0]          req_state,
  input logic [CNT_W-1:0]    sys_count,
  input logic                sys_pwr_en,
  input logic                gic_pwr_en,
  input logic                aon_pwr_en,
  input logic                dram_ret_req,
  input logic                clus_wake_rel,
  input logic                busy,
  input logic [1:0]          sys_state,
  input logic                req_err
);

  AST_RUN_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_state == SYS_RUN && !busy) |-> (sys_pwr_en && gic_pwr_en && aon_pwr_en && !dram_ret_req && !clus_wake_rel)); // R1

  AST_OFF_REQ_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_state == SYS_RUN && !busy && req_valid && req_state == SYS_OFF && clus_state != '1)
    |=> (req_err && sys_state == SYS_RUN && !busy)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> req_err); // R5

  AST_GIC_DOWN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_pwr_en) |-> !gic_pwr_en); // R6

  AST_SLEEP_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_state == SYS_SLEEP && !busy) |-> (!sys_pwr_en && !gic_pwr_en && aon_pwr_en && !dram_ret_req)); // R6

  AST_GIC_UP_AFTER_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gic_pwr_en) |-> sys_pwr_en); // R8

  AST_REL_AFTER_GIC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clus_wake_rel) |-> (gic_pwr_en && sys_pwr_en)); // R8

  AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_state == SYS_DEEP) |=> (sys_state == SYS_DEEP && dram_ret_req && !aon_pwr_en && !sys_pwr_en && !gic_pwr_en)); // R9

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_state == SYS_OFF) |=> (sys_state == SYS_OFF && !dram_ret_req && !aon_pwr_en && !sys_pwr_en)); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    aon_pwr_en |=> (sys_count == CNT_W'($past(sys_count) + CNT_W'(1)))); // R10

  AST_COUNT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !aon_pwr_en |=> $stable(sys_count)); // R10

endmodule

bind soc_pstate_ctrl soc_pstate_ctrl_chk #(.N_CLUS(N_CLUS), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .clus_state    (clus_state),
  .req_valid     (req_valid),
  .req_state     (req_state),
  .sys_count     (sys_count),
  .sys_pwr_en    (sys_pwr_en),
  .gic_pwr_en    (gic_pwr_en),
  .aon_pwr_en    (aon_pwr_en),
  .dram_ret_req  (dram_ret_req),
  .clus_wake_rel (clus_wake_rel),
  .busy          (busy),
  .sys_state     (sys_state),
  .req_err       (req_err)
);

// File: tb/tb_soc_pstate_ctrl.sv
`timescale 1ns/1ps
module tb_soc_pstate_ctrl;

  localparam int N_CLUS = 4;
  localparam int N_WAKE = 4;
  localparam int CNT_W  = 64;
  localparam int S      = 4;

  logic                clk;
  logic                rst_n;
  logic [2*N_CLUS-1:0] clus_state;
  logic                req_valid;
  logic [1:0]          req_state;
  logic                timer_en;
  logic [CNT_W-1:0]    wake_at;
  logic [N_WAKE-1:0]   aon_wake;
  logic [CNT_W-1:0]    sys_count;
  logic                sys_pwr_en, gic_pwr_en, aon_pwr_en, dram_ret_req;
  logic                clus_wake_rel, busy, req_err;
  logic [1:0]          sys_state;

  soc_pstate_ctrl #(.N_CLUS(N_CLUS), .N_WAKE(N_WAKE), .CNT_W(CNT_W), .STEP_CYC(S)) dut (
    .clk(clk), .rst_n(rst_n), .clus_state(clus_state), .req_valid(req_valid),
    .req_state(req_state), .timer_en(timer_en), .wake_at(wake_at), .aon_wake(aon_wake),
    .sys_count(sys_count), .sys_pwr_en(sys_pwr_en), .gic_pwr_en(gic_pwr_en),
    .aon_pwr_en(aon_pwr_en), .dram_ret_req(dram_ret_req), .clus_wake_rel(clus_wake_rel),
    .busy(busy), .sys_state(sys_state), .req_err(req_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit err_exp = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] mkv(input bit s, input bit g, input bit a, input bit r,
                                     input bit w, input bit b, input logic [1:0] st, input bit e);
    return {s, g, a, r, w, b, st, e};
  endfunction

  task automatic expect_v(input string tag, input logic [8:0] e);
    logic [8:0] act;
    act = {sys_pwr_en, gic_pwr_en, aon_pwr_en, dram_ret_req, clus_wake_rel, busy, sys_state, req_err};
    chk(act == e, tag, 64'(act), 64'(e));
  endtask

  function automatic bit legal(input logic [1:0] tgt, input logic [2*N_CLUS-1:0] cs);
    bit any_run;
    bit any_sl;
    bit all_off;
    logic [1:0] c;
    any_run = 0; any_sl = 0; all_off = 1;
    for (int i = 0; i < N_CLUS; i++) begin
      c = cs[2*i +: 2];
      if (c == 2'b00) any_run = 1;
      if (c == 2'b01 || c == 2'b10) any_sl = 1;
      if (c != 2'b11) all_off = 0;
    end
    case (tgt)
      2'b00:   return 1'b1;
      2'b01:   return any_sl && !any_run;
      2'b10:   return !any_run;
      default: return all_off;
    endcase
  endfunction

  function automatic int sleep_len(input logic [63:0] wa, input logic [63:0] c0);
    logic [63:0] entry;
    entry = c0 + 64'(2*S + 1);
    if (wa > entry) return int'(wa - entry) + 1;
    return 1;
  endfunction

  task automatic do_reset();
    logic [63:0] c;
    rst_n = 1'b0; req_valid = 1'b0; aon_wake = '0; timer_en = 1'b0; wake_at = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    err_exp = 1'b0;
    expect_v("R1 reset state", mkv(1, 1, 1, 0, 0, 0, 2'b00, 0));
    c = sys_count;
    @(negedge clk);
    chk(sys_count == c + 64'd1, "R10 count step", sys_count, c + 64'd1);
  endtask

  task automatic issue(input logic [1:0] tgt);
    req_valid = 1'b1;
    req_state = tgt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic enter(input logic [1:0] tgt, input bit poke);
    int n;
    n = (tgt == 2'b01) ? 2*S : 3*S;
    for (int i = 0; i < n; i++) begin
      expect_v(tgt == 2'b01 ? "R6 entry" : "R9 entry",
               mkv(i < S, 0, i < 2*S, tgt == 2'b10, 0, 1, 2'b00, err_exp));
      if (poke && i == 1) begin req_valid = 1'b1; req_state = 2'b11; end
      if (poke && i == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    case (tgt)
      2'b01:   expect_v("R6 settled sleep", mkv(0, 0, 1, 0, 0, 0, 2'b01, err_exp));
      2'b10:   expect_v("R9 settled deep",  mkv(0, 0, 0, 1, 0, 0, 2'b10, err_exp));
      default: expect_v("R9 settled off",   mkv(0, 0, 0, 0, 0, 0, 2'b11, err_exp));
    endcase
  endtask

  task automatic leave_sleep();
    for (int i = 0; i < 3*S; i++) begin
      expect_v("R8 exit order", mkv(1, i >= S, 1, 0, i >= 2*S, 1, 2'b01, err_exp));
      @(negedge clk);
    end
    expect_v("R8 back in run", mkv(1, 1, 1, 0, 0, 0, 2'b00, err_exp));
  endtask

  task automatic sleep_timer(input bit immediate, input bit poke);
    logic [63:0] c0;
    int n;
    int w;
    c0 = sys_count;
    timer_en = 1'b1;
    if (immediate) wake_at = (c0 > 64'd5) ? c0 - 64'($urandom % 5) : 64'd0;
    else begin
      w = $urandom % 20;
      wake_at = c0 + 64'(2*S + 1 + w);
    end
    issue(2'b01);
    enter(2'b01, poke);
    n = 0;
    while (sys_state == 2'b01 && !busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == sleep_len(wake_at, c0), "R7 timer sleep length", 64'(n), 64'(sleep_len(wake_at, c0)));
    timer_en = 1'b0;
    leave_sleep();
  endtask

  task automatic sleep_event();
    int w;
    timer_en = 1'b0;
    issue(2'b01);
    enter(2'b01, 1'b0);
    w = $urandom % 8;
    repeat (w) @(negedge clk);
    expect_v("R7 no wake without cause", mkv(0, 0, 1, 0, 0, 0, 2'b01, err_exp));
    aon_wake = N_WAKE'(1) << ($urandom % N_WAKE);
    @(negedge clk);
    aon_wake = '0;
    leave_sleep();
  endtask

  task automatic deep_or_off(input logic [1:0] tgt);
    logic [63:0] c;
    issue(tgt);
    enter(tgt, 1'b0);
    c = sys_count;
    aon_wake = '1; timer_en = 1'b1; wake_at = '0;
    req_valid = 1'b1; req_state = 2'b00;
    repeat (10) @(negedge clk);
    if (tgt == 2'b10) expect_v("R9 deep ignores stimulus", mkv(0, 0, 0, 1, 0, 0, 2'b10, err_exp));
    else              expect_v("R9 off ignores stimulus",  mkv(0, 0, 0, 0, 0, 0, 2'b11, err_exp));
    chk(sys_count == c, "R10 count frozen", sys_count, c);
    do_reset();
  endtask

  task automatic trial(input logic [1:0] tgt, input logic [2*N_CLUS-1:0] cs);
    clus_state = cs;
    if (!legal(tgt, cs)) begin
      issue(tgt);
      err_exp = 1'b1;
      expect_v(tgt == 2'b01 ? "R3 R5 reject" : "R4 R5 reject", mkv(1, 1, 1, 0, 0, 0, 2'b00, 1));
      @(negedge clk);
    end else if (tgt == 2'b00) begin
      issue(tgt);
      expect_v("R2 run request no change", mkv(1, 1, 1, 0, 0, 0, 2'b00, err_exp));
    end else if (tgt == 2'b01) begin
      if ($urandom % 2) sleep_event();
      else sleep_timer($urandom % 3 == 0, 1'b0);
    end else begin
      deep_or_off(tgt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clus_state = '1; req_state = 2'b00;
    do_reset();

    // R3: all clusters off, so no cluster is sleeping and SLEEP is illegal
    trial(2'b01, 8'hFF);
    do_reset();
    // R4: a sleeping cluster blocks OFF
    trial(2'b11, 8'hFE);
    // R5: the error stays set through a legal sleep with an immediate wake (R7)
    clus_state = 8'hF6;
    sleep_timer(1'b1, 1'b0);
    chk(req_err == 1'b1, "R5 sticky", 64'(req_err), 64'd1);
    do_reset();
    // R2: a request made during the entry sequence is ignored
    clus_state = 8'hFD;
    sleep_timer(1'b0, 1'b1);
    // R3: a running cluster blocks SLEEP
    trial(2'b01, 8'hF4);
    do_reset();
    // R9: legal DEEPSLEEP and OFF
    trial(2'b10, 8'hF9);
    trial(2'b11, 8'hFF);
    // R7: wake from an event line
    clus_state = 8'hEF;
    sleep_event();

    for (int t = 0; t < 60; t++) begin
      logic [2*N_CLUS-1:0] cs;
      logic [1:0] tg;
      if ($urandom % 4 == 0) cs = '1;
      else cs = (2*N_CLUS)'($urandom);
      tg = 2'($urandom);
      trial(tg, cs);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule